// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps the local time of day for a node that timestamps frames and generates or captures timed events. It holds a 48-bit seconds count, a 30-bit nanoseconds count that wraps at one billion, and a 16-bit hidden fraction of a nanosecond. The three fields are driven out together as one 94-bit value: seconds in the top bits, nanoseconds in the middle and the fraction in the lowest 16 bits. On every cycle where the oscillator tick enable is high, the counter adds a per-tick increment. The increment has 8 integer nanosecond bits and 16 fraction bits, so a synchronization loop can trim the counter rate in steps of 1/65536 ns.

Software has three controls. A direct load writes seconds and nanoseconds and clears the fraction. A new increment value changes the rate. A one-shot signed step of up to just under one second moves the time once. The step is held until the next tick and is added together with the normal increment. It borrows from or carries into the seconds field as needed. After the step the increment is the same as before.

Top module: `tod_counter`

## Requirements
- R1: After reset the time output is all zeros and the increment is 40 ns (value 0x280000: integer ns in bits [23:16], fraction in bits [15:0]), so the first tick yields 40 ns.
- R2: In a cycle with tick_en low and no load, the time output does not change.
- R3: The fraction field (time bits [15:0]) adds the increment's fraction bits modulo 65536, and an overflow adds one nanosecond in the same tick.
- R4: The nanoseconds field (time bits [45:16]) never reaches 1,000,000,000. A tick that would pass it subtracts one billion and adds one to the seconds field (bits [93:46]) in the same cycle.
- R5: An increment presented with inc_valid is used from the next cycle on. A tick in the same cycle as the load still uses the old increment.
- R6: A load (set_valid) puts set_sec and set_ns into the time and clears the fraction, whatever tick_en is. It wins over a tick and over an adjustment presented in the same cycle, and it cancels any pending adjustment.
- R7: A positive adjustment (adj_valid, signed adj_ns) is added once, on the first tick after it is presented, together with the increment, carrying into seconds where the sum passes one second. Later ticks add only the increment.
- R8: A negative adjustment that takes nanoseconds below zero adds one billion to the nanoseconds field and subtracts one from the seconds field.
- R9: The seconds field wraps from 2^48-1 to 0.
- R10: A second adjustment presented before a tick replaces the pending one, and only the newest is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Tick enable: advance time this cycle |
| set_valid | input | 1 | Load set_sec/set_ns into the time |
| set_sec | input | 48 | Seconds value to load |
| set_ns | input | 30 | Nanoseconds value to load (below one billion) |
| inc_valid | input | 1 | Load a new per-tick increment |
| inc_value | input | 24 | Increment: [23:16] ns, [15:0] fraction |
| adj_valid | input | 1 | Request a one-shot time step |
| adj_ns | input | 31 | Signed step in ns, magnitude below one billion |
| time_out | output | 94 | {seconds[47:0], nanoseconds[29:0], fraction[15:0]} |

## Verification
The bench targets the carry paths. With a half-nanosecond increment it checks that the fraction overflow adds exactly one nanosecond. It crosses the one-billion boundary to catch a counter that wraps late or forgets the seconds carry. It applies a negative step that forces a borrow from seconds, which a design with unsigned nanosecond arithmetic would wrap to a huge value. It checks the step is not applied twice and that a newer step replaces an older one. Loads are presented together with a tick and a step: a design that gives the load the wrong priority would add a tick, keep the fraction, or apply the cancelled step on the next tick.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_LOAD = 2'd1,
    UPD_STEP = 2'd2
  } tod_upd_e;

  localparam int unsigned TOD_NS_PER_SEC = 32'd1_000_000_000;
endpackage

// File: rtl/tod_rst_sync.sv
module tod_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tod_incr_reg.sv
module tod_incr_reg #(
  parameter int INC_W = 24,
  parameter logic [INC_W-1:0] INC_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [INC_W-1:0] load_val,
  output logic [INC_W-1:0] inc_q
);
  logic [INC_W-1:0] inc_d;

  always_comb begin
    inc_d = inc_q;
    if (load_en) begin
      inc_d = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q <= INC_RST;
    end else if (load_en) begin
      inc_q <= inc_d;
    end
  end
endmodule

// File: rtl/tod_adj_hold.sv
module tod_adj_hold #(
  parameter int ADJ_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [ADJ_W-1:0] load_val,
  input  logic             drop_en,
  output logic             pend_q,
  output logic [ADJ_W-1:0] val_q
);
  logic             pend_d;
  logic [ADJ_W-1:0] val_d;
  logic             upd_en;

  always_comb begin
    pend_d = pend_q;
    val_d  = val_q;
    if (load_en) begin
      pend_d = 1'b1;
      val_d  = load_val;
    end else if (drop_en) begin
      pend_d = 1'b0;
      val_d  = '0;
    end
  end

  assign upd_en = load_en | drop_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      val_q  <= '0;
    end else if (upd_en) begin
      pend_q <= pend_d;
      val_q  <= val_d;
    end
  end
endmodule

// File: rtl/tod_step_calc.sv
module tod_step_calc #(
  parameter int          SEC_W      = 48,
  parameter int          NS_W       = 30,
  parameter int          FRAC_W     = 16,
  parameter int          INC_INT_W  = 8,
  parameter int          ADJ_W      = 31,
  parameter int unsigned NS_PER_SEC = 32'd1_000_000_000
) (
  input  logic [SEC_W-1:0]           sec_in,
  input  logic [NS_W-1:0]            ns_in,
  input  logic [FRAC_W-1:0]          frac_in,
  input  logic [INC_INT_W+FRAC_W-1:0] inc,
  input  logic                       adj_en,
  input  logic [ADJ_W-1:0]           adj_val,
  output logic [SEC_W-1:0]           sec_out,
  output logic [NS_W-1:0]            ns_out,
  output logic [FRAC_W-1:0]          frac_out
);
  localparam int SUM_W = NS_W + 3;
  localparam logic signed [SUM_W-1:0] NS_WRAP = SUM_W'(NS_PER_SEC);

  logic [FRAC_W:0]          frac_sum;
  logic                     frac_cy;
  logic signed [SUM_W-1:0]  ns_base;
  logic signed [SUM_W-1:0]  ns_inc;
  logic signed [SUM_W-1:0]  ns_cy;
  logic signed [SUM_W-1:0]  ns_adj;
  logic signed [SUM_W-1:0]  ns_sum;
  logic signed [SUM_W-1:0]  ns_fix;
  logic                     sec_up;
  logic                     sec_dn;

  // fraction accumulation with carry out
  assign frac_sum = {1'b0, frac_in} + {1'b0, inc[FRAC_W-1:0]};
  assign frac_cy  = frac_sum[FRAC_W];
  assign frac_out = frac_sum[FRAC_W-1:0];

  // operands widened to a signed sum
  assign ns_base = $signed({{(SUM_W-NS_W){1'b0}}, ns_in});
  assign ns_inc  = $signed({{(SUM_W-INC_INT_W){1'b0}}, inc[INC_INT_W+FRAC_W-1:FRAC_W]});
  assign ns_cy   = $signed({{(SUM_W-1){1'b0}}, frac_cy});
  assign ns_adj  = adj_en ? $signed({{(SUM_W-ADJ_W){adj_val[ADJ_W-1]}}, adj_val})
                          : '0;
  assign ns_sum  = ns_base + ns_inc + ns_cy + ns_adj;

  // normalize into one second
  always_comb begin
    sec_up = 1'b0;
    sec_dn = 1'b0;
    ns_fix = ns_sum;
    if (ns_sum < 0) begin
      sec_dn = 1'b1;
      ns_fix = ns_sum + NS_WRAP;
    end else if (ns_sum >= NS_WRAP) begin
      sec_up = 1'b1;
      ns_fix = ns_sum - NS_WRAP;
    end
  end

  assign ns_out = NS_W'(ns_fix);

  always_comb begin
    sec_out = sec_in;
    if (sec_up) begin
      sec_out = sec_in + SEC_W'(1);
    end else if (sec_dn) begin
      sec_out = sec_in - SEC_W'(1);
    end
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int          SEC_W       = 48,
  parameter int          NS_W        = 30,
  parameter int          FRAC_W      = 16,
  parameter int          INC_INT_W   = 8,
  parameter int          ADJ_W       = 31,
  parameter int          NOM_INC_NS  = 40,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned NS_PER_SEC  = TOD_NS_PER_SEC,
  localparam int         INC_W       = INC_INT_W + FRAC_W,
  localparam int         TIME_W      = SEC_W + NS_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              set_valid,
  input  logic [SEC_W-1:0]  set_sec,
  input  logic [NS_W-1:0]   set_ns,
  input  logic              inc_valid,
  input  logic [INC_W-1:0]  inc_value,
  input  logic              adj_valid,
  input  logic [ADJ_W-1:0]  adj_ns,
  output logic [TIME_W-1:0] time_out
);
  localparam logic [INC_W-1:0] INC_RST = INC_W'(NOM_INC_NS) << FRAC_W;

  logic               rst_sync_n;
  logic [INC_W-1:0]   inc_q;
  logic               adj_pend;
  logic [ADJ_W-1:0]   adj_val;
  logic               adj_apply;
  logic               adj_drop;
  logic               adj_load;
  tod_upd_e           upd_mode;
  logic               time_en;

  logic [SEC_W-1:0]   sec_q,  sec_d,  sec_step;
  logic [NS_W-1:0]    ns_q,   ns_d,   ns_step;
  logic [FRAC_W-1:0]  frac_q, frac_d, frac_step;

  tod_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tod_incr_reg #(.INC_W(INC_W), .INC_RST(INC_RST)) u_incr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (inc_valid),
    .load_val (inc_value),
    .inc_q    (inc_q)
  );

  // update mode: load beats tick
  always_comb begin
    if (set_valid) begin
      upd_mode = UPD_LOAD;
    end else if (tick_en) begin
      upd_mode = UPD_STEP;
    end else begin
      upd_mode = UPD_HOLD;
    end
  end

  assign adj_apply = adj_pend & (upd_mode == UPD_STEP);
  assign adj_load  = adj_valid & ~set_valid;
  assign adj_drop  = set_valid | adj_apply;

  tod_adj_hold #(.ADJ_W(ADJ_W)) u_adj (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (adj_load),
    .load_val (adj_ns),
    .drop_en  (adj_drop),
    .pend_q   (adj_pend),
    .val_q    (adj_val)
  );

  tod_step_calc #(
    .SEC_W      (SEC_W),
    .NS_W       (NS_W),
    .FRAC_W     (FRAC_W),
    .INC_INT_W  (INC_INT_W),
    .ADJ_W      (ADJ_W),
    .NS_PER_SEC (NS_PER_SEC)
  ) u_step (
    .sec_in   (sec_q),
    .ns_in    (ns_q),
    .frac_in  (frac_q),
    .inc      (inc_q),
    .adj_en   (adj_apply),
    .adj_val  (adj_val),
    .sec_out  (sec_step),
    .ns_out   (ns_step),
    .frac_out (frac_step)
  );

  // next-state selection
  always_comb begin
    sec_d  = sec_q;
    ns_d   = ns_q;
    frac_d = frac_q;
    unique case (upd_mode)
      UPD_LOAD: begin
        sec_d  = set_sec;
        ns_d   = set_ns;
        frac_d = '0;
      end
      UPD_STEP: begin
        sec_d  = sec_step;
        ns_d   = ns_step;
        frac_d = frac_step;
      end
      default: begin
        sec_d  = sec_q;
        ns_d   = ns_q;
        frac_d = frac_q;
      end
    endcase
  end

  assign time_en = (upd_mode != UPD_HOLD);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sec_q  <= '0;
      ns_q   <= '0;
      frac_q <= '0;
    end else if (time_en) begin
      sec_q  <= sec_d;
      ns_q   <= ns_d;
      frac_q <= frac_d;
    end
  end

  assign time_out = {sec_q, ns_q, frac_q};
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int          SEC_W      = 48,
  parameter int          NS_W       = 30,
  parameter int          FRAC_W     = 16,
  parameter int unsigned NS_PER_SEC = 32'd1_000_000_000,
  localparam int         TIME_W     = SEC_W + NS_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              set_valid,
  input logic [SEC_W-1:0]  set_sec,
  input logic [NS_W-1:0]   set_ns,
  input logic              adj_valid,
  input logic              adj_pend,
  input logic [TIME_W-1:0] time_out
);
  localparam logic [NS_W-1:0] NS_LIM = NS_W'(NS_PER_SEC);

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !set_valid) |=> $stable(time_out));

  // R4
  ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_out[FRAC_W +: NS_W] < NS_LIM);

  // R6
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> (time_out == {$past(set_sec), $past(set_ns), {FRAC_W{1'b0}}}));

  // R7
  step_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_pend && tick_en && !set_valid && !adj_valid) |=> !adj_pend);
endmodule

bind tod_counter tod_counter_chk #(
  .SEC_W      (SEC_W),
  .NS_W       (NS_W),
  .FRAC_W     (FRAC_W),
  .NS_PER_SEC (NS_PER_SEC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tick_en   (tick_en),
  .set_valid (set_valid),
  .set_sec   (set_sec),
  .set_ns    (set_ns),
  .adj_valid (adj_valid),
  .adj_pend  (adj_pend),
  .time_out  (time_out)
);

// File: tb/tod_counter_test.sv
module tod_counter_test;
  logic               clk;
  logic               rst_n;
  logic               tick_en;
  logic               set_valid;
  logic [47:0]        set_sec;
  logic [29:0]        set_ns;
  logic               inc_valid;
  logic [23:0]        inc_value;
  logic               adj_valid;
  logic signed [30:0] adj_ns;
  logic [93:0]        time_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  tod_counter uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .set_valid (set_valid),
    .set_sec   (set_sec),
    .set_ns    (set_ns),
    .inc_valid (inc_valid),
    .inc_value (inc_value),
    .adj_valid (adj_valid),
    .adj_ns    (adj_ns),
    .time_out  (time_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [47:0] s,
                     input logic [29:0] n, input logic [15:0] f);
    logic [93:0] exp_t;
    exp_t = {s, n, f};
    total++;
    if (time_out !== exp_t) begin
      bad++;
      $display("FAIL %s: act sec=%0d ns=%0d frac=%h exp sec=%0d ns=%0d frac=%h",
               req, time_out[93:46], time_out[45:16], time_out[15:0], s, n, f);
    end
  endtask

  // one cycle: drive at negedge, return at the next negedge
  task automatic cyc(input logic tk, input logic sv, input logic [47:0] s,
                     input logic [29:0] n, input logic iv, input logic [23:0] iw,
                     input logic av, input logic signed [30:0] aw);
    tick_en   = tk;
    set_valid = sv;
    set_sec   = s;
    set_ns    = n;
    inc_valid = iv;
    inc_value = iw;
    adj_valid = av;
    adj_ns    = aw;
    @(negedge clk);
    tick_en   = 1'b0;
    set_valid = 1'b0;
    inc_valid = 1'b0;
    adj_valid = 1'b0;
  endtask

  task automatic tick();
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic load(input logic [47:0] s, input logic [29:0] n);
    cyc(0, 1, s, n, 0, 0, 0, 0);
  endtask

  task automatic set_inc(input logic [23:0] iw);
    cyc(0, 0, 0, 0, 1, iw, 0, 0);
  endtask

  task automatic t_reset();
    chk("R1 reset value", 0, 0, 0);
    tick();
    chk("R1 default increment", 0, 40, 0);
  endtask

  task automatic t_hold();
    load(12, 500);
    repeat (5) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 no tick holds", 12, 500, 0);
  endtask

  task automatic t_inc_load();
    load(5, 0);
    cyc(1, 0, 0, 0, 1, 24'h00_8000, 0, 0);
    chk("R5 old increment in load cycle", 5, 40, 0);
    tick();
    chk("R3 half ns fraction", 5, 40, 16'h8000);
    tick();
    chk("R3 fraction carry", 5, 41, 16'h0000);
    tick();
    chk("R5 trimmed rate", 5, 41, 16'h8000);
    set_inc(24'h28_0000);
  endtask

  task automatic t_wrap();
    load(7, 999_999_980);
    tick();
    chk("R4 ns wrap into seconds", 8, 20, 0);
    load(7, 999_999_960);
    tick();
    chk("R4 reach limit wraps to zero", 8, 0, 0);
  endtask

  task automatic t_load_prio();
    set_inc(24'h00_4000);
    load(9, 0);
    tick();
    chk("R3 quarter ns fraction", 9, 0, 16'h4000);
    cyc(1, 1, 9, 123, 0, 0, 1, 31'sd500);
    chk("R6 load beats tick and step, clears fraction", 9, 123, 0);
    tick();
    chk("R6 cancelled step not applied", 9, 123, 16'h4000);
    set_inc(24'h28_0000);
  endtask

  task automatic t_pos_adj();
    load(3, 100);
    cyc(0, 0, 0, 0, 0, 0, 1, 31'sd1000);
    chk("R7 step waits for tick", 3, 100, 0);
    tick();
    chk("R7 step with increment", 3, 1140, 0);
    tick();
    chk("R7 step applied once", 3, 1180, 0);
    load(3, 999_999_000);
    cyc(0, 0, 0, 0, 0, 0, 1, 31'sd999_999_999);
    tick();
    chk("R7 large step carries", 4, 999_999_039, 0);
  endtask

  task automatic t_neg_adj();
    load(3, 100);
    cyc(0, 0, 0, 0, 0, 0, 1, -31'sd500);
    tick();
    chk("R8 borrow from seconds", 2, 999_999_640, 0);
    load(3, 1000);
    cyc(0, 0, 0, 0, 0, 0, 1, -31'sd500);
    tick();
    chk("R8 negative step no borrow", 3, 540, 0);
  endtask

  task automatic t_sec_wrap();
    load(48'hFFFF_FFFF_FFFF, 999_999_990);
    tick();
    chk("R9 seconds wrap", 0, 30, 0);
  endtask

  task automatic t_replace();
    load(1, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 31'sd100);
    cyc(0, 0, 0, 0, 0, 0, 1, 31'sd7);
    tick();
    chk("R10 newest step wins", 1, 47, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    tick_en = 0; set_valid = 0; set_sec = 0; set_ns = 0;
    inc_valid = 0; inc_value = 0; adj_valid = 0; adj_ns = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hold();
    t_inc_load();
    t_wrap();
    t_load_prio();
    t_pos_adj();
    t_neg_adj();
    t_sec_wrap();
    t_replace();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: act running exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule